// File: doc/BRIEF.md
# MAC Control Frame Receive Filter

This block makes the receive-side decision for each incoming Ethernet frame once the header parser has pulled out its destination address, type/length field, control opcode and the 16-bit parameter after the opcode. For each frame it decides on one of three outcomes. A frame can be forwarded to the receive FIFO, silently dropped, or marked invalid. When the frame is a Pause frame that should throttle the local transmitter, the block also raises a pause request that carries the pause quanta.

A frame counts as a MAC Control frame when its type/length field equals 0x8808. A MAC Control frame is a Pause frame when its opcode equals 0x0001. The pause quanta is the following 16-bit field, taken big-endian as presented on `pause_param`. Three configuration inputs set the policy: a two-bit pass-through mode, a switch for the reserved-address check, and a switch that lets received Pause frames reach the transmitter. The parser pulses `hdr_valid` for one clock when the header fields are stable. All results appear as registered one-cycle pulses on the following clock.

Top module: `mcf_rx_filter`

## Requirements
- R1: A frame whose type/length field is not 0x8808 is forwarded (`fwd`=1) and never raises `pause_req`, whatever the configuration.
- R2: With `cfg_pass`=00, every valid control frame (Pause or not) is dropped (`drop`=1, `fwd`=0).
- R3: With `cfg_pass`=01, a valid control frame whose opcode is not 0x0001 is forwarded, and a Pause frame (opcode 0x0001) is dropped.
- R4: With `cfg_pass`=10 or 11, every valid control frame, Pause frames included, is forwarded.
- R5: With `cfg_addr_chk`=1, a control frame whose destination differs from 01-80-C2-00-00-01 (`dst_addr`[47:40]=0x01 … [7:0]=0x01) is marked invalid (`bad`=1), is not forwarded or dropped, and raises no pause request.
- R6: With `cfg_addr_chk`=0, a control frame with any destination address is handled as if the address matched.
- R7: A valid Pause frame raises `pause_req` with `pause_quanta` equal to that frame's `pause_param` exactly when `cfg_pause_en`=1. With `cfg_pause_en`=0 it raises nothing, and its forward/drop outcome is unchanged.
- R8: Exactly one of `fwd`, `drop` and `bad` is high in the cycle after each `hdr_valid`. In every other cycle all of them, `pause_req` and `pause_quanta` are zero. Back-to-back strobes give back-to-back results.
- R9: While `rst_n` is low at a clock edge, all outputs go to zero on that edge, even if `hdr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | One-cycle strobe: header fields are valid |
| dst_addr | input | 48 | Destination address, first octet in bits 47:40 |
| len_type | input | 16 | Type/length field |
| opcode | input | 16 | MAC Control opcode |
| pause_param | input | 16 | Field following the opcode (pause time) |
| cfg_pass | input | 2 | Pass-through mode: 00 none, 01 non-Pause only, 1x all |
| cfg_addr_chk | input | 1 | 1 = require the reserved multicast destination |
| cfg_pause_en | input | 1 | 1 = received Pause frames pause the transmitter |
| fwd | output | 1 | Frame goes to the receive FIFO |
| drop | output | 1 | Frame is discarded |
| bad | output | 1 | Frame is an invalid control frame |
| pause_req | output | 1 | Pause request to the transmitter |
| pause_quanta | output | 16 | Pause time carried with the request, zero otherwise |

## Verification
The assertions assume that the header fields and configuration bits are stable in the cycle that `hdr_valid` is high, because each property compares the registered verdict with the inputs sampled at that strobe. The assertions do not assume any spacing between strobes. The stimulus changes fields and configuration only on the falling edge, together with the strobe, so every rising edge sees one consistent header. The strobe runs both back-to-back and with idle gaps, and reset is pulsed once while a strobe is pending.

// File: rtl/mcf_rx_pkg.sv
`timescale 1ns/1ps
// Package: mcf_rx_pkg
// Shared types for the MAC Control receive filter. Holds the pass-through
// mode encoding, the per-frame classification record and the verdict record.
package mcf_rx_pkg;

    // Pass-through selection; both upper codes mean "forward everything".
    typedef enum logic [1:0] {
        PASS_NONE     = 2'b00,
        PASS_NONPAUSE = 2'b01,
        PASS_ALL      = 2'b10,
        PASS_ALL_ALT  = 2'b11
    } pass_mode_e;

    // What the header says about the frame.
    typedef struct packed {
        logic is_ctrl;   // type/length marks a MAC Control frame
        logic is_pause;  // control frame carrying the Pause opcode
        logic da_hit;    // destination equals the reserved multicast address
    } frame_class_t;

    // Decision produced for one frame.
    typedef struct packed {
        logic fwd;
        logic drop;
        logic bad;
        logic pause;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{fwd: 1'b0, drop: 1'b0, bad: 1'b0, pause: 1'b0};

endpackage

// File: rtl/mcf_da_match.sv
`timescale 1ns/1ps
// Module: mcf_da_match
// Compares a destination address with a fixed reserved address one octet
// lane at a time and reduces the lane results.
// Assumes: DA_W is a multiple of 8.
module mcf_da_match #(
    parameter int          DA_W    = 48,
    parameter logic [DA_W-1:0] RSVD_DA = 48'h0180_C200_0001
) (
    input  logic [DA_W-1:0] dst_addr,
    output logic            hit
);
    localparam int LANES = DA_W / 8;

    logic [LANES-1:0] lane_eq;

    // One comparator per octet lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (dst_addr[g*8 +: 8] == RSVD_DA[g*8 +: 8]);
    end

    // The address hits only when every lane agrees.
    assign hit = &lane_eq;

endmodule

// File: rtl/mcf_classify.sv
`timescale 1ns/1ps
// Module: mcf_classify
// Works out from the parsed header whether the frame is a MAC Control frame,
// whether it is a Pause frame, and whether the destination is the reserved
// address. Purely combinational.
// Assumes: the header inputs are stable while the parser strobe is high.
module mcf_classify
    import mcf_rx_pkg::*;
#(
    parameter int               DA_W      = 48,
    parameter int               FLD_W     = 16,
    parameter logic [FLD_W-1:0] CTRL_TYPE = 16'h8808,
    parameter logic [FLD_W-1:0] PAUSE_OP  = 16'h0001,
    parameter logic [DA_W-1:0]  RSVD_DA   = 48'h0180_C200_0001
) (
    input  logic [DA_W-1:0]  dst_addr,
    input  logic [FLD_W-1:0] len_type,
    input  logic [FLD_W-1:0] opcode,
    output frame_class_t     cls
);
    logic da_hit;

    mcf_da_match #(
        .DA_W    (DA_W),
        .RSVD_DA (RSVD_DA)
    ) u_da (
        .dst_addr (dst_addr),
        .hit      (da_hit)
    );

    // Assemble the classification record.
    always_comb begin
        cls.is_ctrl  = (len_type == CTRL_TYPE);
        cls.is_pause = (len_type == CTRL_TYPE) && (opcode == PAUSE_OP);
        cls.da_hit   = da_hit;
    end

endmodule

// File: rtl/mcf_policy.sv
`timescale 1ns/1ps
// Module: mcf_policy
// Applies the configured policy to a classified frame and yields the verdict.
// Exactly one of fwd/drop/bad is set. A pause is requested only for an
// accepted Pause frame while pausing is enabled.
// Assumes: the classification record matches the current header.
module mcf_policy
    import mcf_rx_pkg::*;
(
    input  frame_class_t cls,
    input  logic [1:0]   cfg_pass,
    input  logic         cfg_addr_chk,
    input  logic         cfg_pause_en,
    output verdict_t     vd
);
    pass_mode_e mode;
    logic       addr_ok;
    logic       pass_it;

    // Decode the pass-through mode into a forward decision for control frames.
    always_comb begin
        mode    = pass_mode_e'(cfg_pass);
        addr_ok = cls.da_hit || !cfg_addr_chk;
        unique case (mode)
            PASS_NONE:     pass_it = 1'b0;
            PASS_NONPAUSE: pass_it = !cls.is_pause;
            PASS_ALL,
            PASS_ALL_ALT:  pass_it = 1'b1;
            default:       pass_it = 1'b0;
        endcase
    end

    // Select the outcome for this frame.
    always_comb begin
        vd = VERDICT_IDLE;
        if (!cls.is_ctrl) begin
            vd.fwd = 1'b1;
        end else if (!addr_ok) begin
            vd.bad = 1'b1;
        end else begin
            vd.fwd   = pass_it;
            vd.drop  = !pass_it;
            vd.pause = cls.is_pause && cfg_pause_en;
        end
    end

endmodule

// File: rtl/mcf_rx_filter.sv
`timescale 1ns/1ps
// Module: mcf_rx_filter (top)
// Receive-side MAC Control frame filter. Classifies each parsed header,
// applies the configured policy and registers the result, so every output
// is a one-cycle pulse on the clock after hdr_valid.
// Assumes: the header fields and configuration are stable while hdr_valid is high.
module mcf_rx_filter
    import mcf_rx_pkg::*;
#(
    parameter int               DA_W      = 48,
    parameter int               FLD_W     = 16,
    parameter logic [FLD_W-1:0] CTRL_TYPE = 16'h8808,
    parameter logic [FLD_W-1:0] PAUSE_OP  = 16'h0001,
    parameter logic [DA_W-1:0]  RSVD_DA   = 48'h0180_C200_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [DA_W-1:0]  dst_addr,
    input  logic [FLD_W-1:0] len_type,
    input  logic [FLD_W-1:0] opcode,
    input  logic [FLD_W-1:0] pause_param,
    input  logic [1:0]       cfg_pass,
    input  logic             cfg_addr_chk,
    input  logic             cfg_pause_en,
    output logic             fwd,
    output logic             drop,
    output logic             bad,
    output logic             pause_req,
    output logic [FLD_W-1:0] pause_quanta
);
    frame_class_t cls;
    verdict_t     vd_now;
    verdict_t     vd_q;
    logic [FLD_W-1:0] quanta_q;

    mcf_classify #(
        .DA_W      (DA_W),
        .FLD_W     (FLD_W),
        .CTRL_TYPE (CTRL_TYPE),
        .PAUSE_OP  (PAUSE_OP),
        .RSVD_DA   (RSVD_DA)
    ) u_cls (
        .dst_addr (dst_addr),
        .len_type (len_type),
        .opcode   (opcode),
        .cls      (cls)
    );

    mcf_policy u_pol (
        .cls          (cls),
        .cfg_pass     (cfg_pass),
        .cfg_addr_chk (cfg_addr_chk),
        .cfg_pause_en (cfg_pause_en),
        .vd           (vd_now)
    );

    // Register the verdict for one cycle; idle when no header is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q     <= VERDICT_IDLE;
            quanta_q <= '0;
        end else if (hdr_valid) begin
            vd_q     <= vd_now;
            quanta_q <= vd_now.pause ? pause_param : '0;
        end else begin
            vd_q     <= VERDICT_IDLE;
            quanta_q <= '0;
        end
    end

    // Drive the outputs from the registered verdict.
    assign fwd          = vd_q.fwd;
    assign drop         = vd_q.drop;
    assign bad          = vd_q.bad;
    assign pause_req    = vd_q.pause;
    assign pause_quanta = quanta_q;

endmodule

// File: rtl/mcf_rx_filter_chk.sv
`timescale 1ns/1ps
// Module: mcf_rx_filter_chk
// Protocol checker bound to mcf_rx_filter. Relates each registered verdict
// to the header and configuration sampled on the preceding strobe.
// Assumes: inputs are stable across the strobe cycle.
module mcf_rx_filter_chk #(
    parameter int               DA_W      = 48,
    parameter int               FLD_W     = 16,
    parameter logic [FLD_W-1:0] CTRL_TYPE = 16'h8808,
    parameter logic [FLD_W-1:0] PAUSE_OP  = 16'h0001,
    parameter logic [DA_W-1:0]  RSVD_DA   = 48'h0180_C200_0001
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic [DA_W-1:0]  dst_addr,
    input logic [FLD_W-1:0] len_type,
    input logic [FLD_W-1:0] opcode,
    input logic [FLD_W-1:0] pause_param,
    input logic [1:0]       cfg_pass,
    input logic             cfg_addr_chk,
    input logic             cfg_pause_en,
    input logic             fwd,
    input logic             drop,
    input logic             bad,
    input logic             pause_req,
    input logic [FLD_W-1:0] pause_quanta
);
    logic ctl_ok;
    logic ctl_pause_ok;

    // Control frame whose address passes the configured check.
    assign ctl_ok       = (len_type == CTRL_TYPE) && (!cfg_addr_chk || dst_addr == RSVD_DA);
    assign ctl_pause_ok = ctl_ok && (opcode == PAUSE_OP);

    a_r1_plain_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && len_type != CTRL_TYPE |=> fwd && !pause_req);

    a_r2_none_drops: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && ctl_ok && cfg_pass == 2'b00 |=> drop && !fwd);

    a_r4_all_passes: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && ctl_ok && cfg_pass[1] |=> fwd);

    a_r5_bad_address: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && len_type == CTRL_TYPE && cfg_addr_chk && dst_addr != RSVD_DA
        |=> bad && !pause_req);

    a_r7_pause_issued: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && ctl_pause_ok && cfg_pause_en
        |=> pause_req && pause_quanta == $past(pause_param));

    a_r7_pause_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !cfg_pause_en |=> !pause_req);

    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> $onehot({fwd, drop, bad}));

    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !fwd && !drop && !bad && !pause_req && pause_quanta == '0);

endmodule

bind mcf_rx_filter mcf_rx_filter_chk #(
    .DA_W      (DA_W),
    .FLD_W     (FLD_W),
    .CTRL_TYPE (CTRL_TYPE),
    .PAUSE_OP  (PAUSE_OP),
    .RSVD_DA   (RSVD_DA)
) u_chk (.*);

// File: tb/sim_mcf_rx_filter.sv
`timescale 1ns/1ps
// Scoreboard bench for mcf_rx_filter. The driver computes the expected
// verdict from the requirements and queues it; the monitor checks outputs
// just after each rising edge.
module sim_mcf_rx_filter;
    localparam logic [47:0] RSVD = 48'h0180_C200_0001;

    typedef struct {
        logic        f, d, b, p;
        logic [15:0] q;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [15:0] len_type = '0, opcode = '0, pause_param = '0;
    logic [1:0]  cfg_pass = 2'b00;
    logic        cfg_addr_chk = 1'b1, cfg_pause_en = 1'b1;
    logic        fwd, drop, bad, pause_req;
    logic [15:0] pause_quanta;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    mcf_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .dst_addr(dst_addr),
        .len_type(len_type), .opcode(opcode), .pause_param(pause_param),
        .cfg_pass(cfg_pass), .cfg_addr_chk(cfg_addr_chk), .cfg_pause_en(cfg_pause_en),
        .fwd(fwd), .drop(drop), .bad(bad), .pause_req(pause_req), .pause_quanta(pause_quanta)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected verdict written from the requirement list.
    function automatic exp_t model(logic [47:0] da, logic [15:0] lt, logic [15:0] op,
                                   logic [15:0] pp, logic [1:0] ps, logic ac, logic pe,
                                   string tag);
        exp_t e;
        logic ctl, pau;
        e.f = 0; e.d = 0; e.b = 0; e.p = 0; e.q = '0; e.tag = tag;
        ctl = (lt == 16'h8808);
        pau = ctl && (op == 16'h0001);
        if (!ctl) e.f = 1;
        else if (ac && da != RSVD) e.b = 1;
        else begin
            e.f = (ps == 2'b00) ? 1'b0 : (ps == 2'b01) ? !pau : 1'b1;
            e.d = !e.f;
            e.p = pau && pe;
            e.q = e.p ? pp : 16'h0;
        end
        return e;
    endfunction

    // Driver: present one header on the falling edge and queue its expectation.
    task automatic send(logic [47:0] da, logic [15:0] lt, logic [15:0] op, logic [15:0] pp,
                        logic [1:0] ps, logic ac, logic pe, string tag);
        @(negedge clk);
        dst_addr = da; len_type = lt; opcode = op; pause_param = pp;
        cfg_pass = ps; cfg_addr_chk = ac; cfg_pause_en = pe;
        hdr_valid = 1'b1;
        sb.push_back(model(da, lt, op, pp, ps, ac, pe, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hdr_valid = 1'b0;
        end
    endtask

    // Monitor: compare just after each rising edge; an empty queue means quiet outputs.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            exp_t e;
            if (sb.size() > 0) e = sb.pop_front();
            else begin
                e.f = 0; e.d = 0; e.b = 0; e.p = 0; e.q = '0; e.tag = "R8";
            end
            check(e.tag, {15'b0, fwd},       {15'b0, e.f}, "fwd");
            check(e.tag, {15'b0, drop},      {15'b0, e.d}, "drop");
            check(e.tag, {15'b0, bad},       {15'b0, e.b}, "bad");
            check(e.tag, {15'b0, pause_req}, {15'b0, e.p}, "pause_req");
            check(e.tag, pause_quanta,       e.q,          "pause_quanta");
        end
    end

    // Watchdog: an expired timer counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: outputs are zero while in reset, even with a strobe pending.
        hdr_valid = 1'b1; len_type = 16'h0800;
        repeat (3) @(posedge clk);
        #1;
        check("R9", {12'b0, fwd, drop, bad, pause_req}, 16'h0, "flags in reset");
        check("R9", pause_quanta, 16'h0, "quanta in reset");
        @(negedge clk); hdr_valid = 1'b0; rst_n = 1'b1;
        idle(2);

        // R1: ordinary frames are forwarded in every mode.
        send(48'h1122_3344_5566, 16'h0800, 16'h0001, 16'h1234, 2'b00, 1, 1, "R1");
        send(RSVD,               16'h86DD, 16'h0001, 16'h00FF, 2'b01, 1, 1, "R1");
        send(48'hFFFF_FFFF_FFFF, 16'h0040, 16'h0000, 16'h0000, 2'b11, 0, 1, "R1");
        idle(1);
        // R2: mode 00 drops control frames; the pause still reaches the transmitter (R7).
        send(RSVD, 16'h8808, 16'h0001, 16'h0ABC, 2'b00, 1, 1, "R2");
        send(RSVD, 16'h8808, 16'h0003, 16'h5555, 2'b00, 1, 1, "R2");
        idle(2);
        // R3: mode 01 forwards non-Pause control frames only.
        send(RSVD, 16'h8808, 16'h0002, 16'h1111, 2'b01, 1, 1, "R3");
        send(RSVD, 16'h8808, 16'h0001, 16'hFFFF, 2'b01, 1, 1, "R3");
        // R4: modes 10 and 11 forward every control frame.
        send(RSVD, 16'h8808, 16'h0001, 16'h0001, 2'b10, 1, 1, "R4");
        send(RSVD, 16'h8808, 16'h0004, 16'h2222, 2'b11, 1, 1, "R4");
        send(RSVD, 16'h8808, 16'h0001, 16'h8000, 2'b11, 1, 0, "R4");
        idle(1);
        // R5: a wrong destination with checking on is invalid, with no pause.
        send(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0777, 2'b10, 1, 1, "R5");
        send(48'h8180_C200_0001, 16'h8808, 16'h0005, 16'h0000, 2'b00, 1, 1, "R5");
        // R6: the same frames are accepted with checking off.
        send(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0777, 2'b10, 0, 1, "R6");
        send(48'h0000_0000_0000, 16'h8808, 16'h0005, 16'h0000, 2'b00, 0, 1, "R6");
        idle(1);
        // R7: pausing disabled blocks the request but keeps the outcome.
        send(RSVD, 16'h8808, 16'h0001, 16'hBEEF, 2'b00, 1, 0, "R7");
        send(RSVD, 16'h8808, 16'h0001, 16'hBEEF, 2'b00, 1, 1, "R7");
        send(RSVD, 16'h8808, 16'h0001, 16'h0000, 2'b10, 0, 1, "R7");
        idle(3);
        // R8: a long back-to-back run with mixed headers.
        for (int i = 0; i < 24; i++) begin
            send((i % 3 == 0) ? RSVD : 48'h0180_C200_0000 + 48'(i),
                 (i % 4 == 0) ? 16'h0800 : 16'h8808,
                 16'(i % 3), 16'(i * 16'h0101),
                 2'(i), 1'(i >> 2), 1'(i >> 1), "R8");
        end
        idle(3);
        // R9: a reset edge overrides a strobe in the same cycle.
        @(negedge clk);
        hdr_valid = 1'b1; len_type = 16'h0800; rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9", {12'b0, fwd, drop, bad, pause_req}, 16'h0, "flags after reset edge");
        @(negedge clk); hdr_valid = 1'b0; rst_n = 1'b1;
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule